// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading one page table entry (PTE) from memory. The upper 20 address bits select the page and the lower 12 bits pass through as the offset. The PTE sits at a table base register plus four times the page number. A context switch changes only the base register.

Once it has fetched the entry, the walker checks it. A page must be valid and resident, and its 2-bit protection field must allow the access kind. If any check fails, the walker returns a fault code and no address. If all checks pass, it returns the frame number with the unchanged offset. It also writes the PTE back to memory when the access changes a status bit: the reference bit on any access, or the modify bit on a write. A missing page gives a fault code of its own, so the fault handler can tell a recoverable page-in from an illegal access.

PTE layout, 32 bits:

| Bits | Field |
|------|-------|
| 31 | modify (M) |
| 30 | reference (Ref) |
| 29 | valid (V) |
| 28:27 | protection |
| 26:7 | frame number |
| 0 | resident (Res) |

Top module: `pgw_top`

## Requirements
- R1: After reset `reqReady` is 1 and `memReq` and `respValid` are 0.
- R2: After a request is taken, the walker raises `memReq` with `memWe`=0 and `memAddr` = base + (va[31:12] << 2). It holds `memReq`, `memWe` and `memAddr` unchanged until a cycle with `memReady`=1. `memRdata` is taken in that cycle.
- R3: A request is taken only on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 1 only while idle. A `reqValid` held during a walk starts no extra memory read and gives no extra response.
- R4: If the checks pass, `respCode` is 00 and `respPa` = {PTE[26:7], va[11:0]}.
- R5: If V=0, `respCode` is 01. This takes priority over every other check. On any fault `respPa` is 0.
- R6: If V=1 and Res=0, `respCode` is 10.
- R7: Access kinds (`reqKind`): 00 read, 01 write, 10 fetch, 11 reserved. Protection values: 00 none, 01 read-only, 10 read/write, 11 read/execute. A read is allowed when protection is not 00. A write is allowed only with 10, and a fetch only with 11. Kind 11 is never allowed. A page that is valid and resident but not allowed gives `respCode` 11.
- R8: The walker writes the PTE back to the same address only after a successful check, and only when Ref is 0, or when the kind is write and M is 0. The value written is the PTE with Ref set, and also M set on a write. No write happens on a fault or when the bits are already set.
- R9: A pulse on `baseWrEn` loads `baseWrData` into the base register. Requests taken on later edges use the new base.
- R10: `respValid` is a one-cycle pulse. It is high two cycles after the cycle in which the PTE read completes when there is no writeback. With a writeback, it is high in the cycle after the write completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseWrEn | input | 1 | Load the table base register |
| baseWrData | input | 32 | New table base (physical) |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVa | input | 32 | Virtual address |
| reqKind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| respValid | output | 1 | Result pulse |
| respPa | output | 32 | Physical address (0 on fault) |
| respCode | output | 2 | Result: 00 ok, 01 invalid, 10 not resident, 11 protection |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | PTE address |
| memWdata | output | 32 | Updated PTE for writeback |
| memReady | input | 1 | Memory access completes this cycle |
| memRdata | input | 32 | PTE read data |

## Verification
The bench memory model adds a latency of zero to three cycles to each access. It records the cycle of every completed access. For each request, the scoreboard stores the expected delay from the last completed access to `respValid`: two cycles after a read-only walk, one cycle after a writeback. The monitor samples on falling edges and checks that delay, together with the address and code. After each result, the driver compares the model's PTE contents, read address and number of writes with values it worked out beforehand from R2 and R8.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int AddrW  = 32;
  localparam int OffW   = 12;
  localparam int VpnW   = AddrW - OffW;
  localparam int PteW   = 32;
  localparam int PfnLo  = 7;
  localparam int ProtLo = PfnLo + VpnW;
  localparam int ValidB = ProtLo + 2;
  localparam int RefB   = ValidB + 1;
  localparam int ModB   = RefB + 1;
  localparam int ResB   = 0;

  typedef enum logic [1:0] {
    kRead  = 2'b00,
    kWrite = 2'b01,
    kFetch = 2'b10,
    kResv  = 2'b11
  } acc_kind_t;

  typedef enum logic [1:0] {
    fNone    = 2'b00,
    fInvalid = 2'b01,
    fAbsent  = 2'b10,
    fProt    = 2'b11
  } fault_t;

  typedef struct packed {
    logic takeReq;
    logic takePte;
    logic takeResult;
  } pgw_strobe_t;
endpackage

// File: rtl/pgw_dp.sv
module pgw_dp
  import pgw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pgw_strobe_t      strobe,
  input  logic             baseWrEn,
  input  logic [AddrW-1:0] baseWrData,
  input  logic [AddrW-1:0] reqVa,
  input  logic [1:0]       reqKind,
  input  logic [PteW-1:0]  memRdata,
  output logic [AddrW-1:0] pteAddr,
  output logic [PteW-1:0]  pteNew,
  output fault_t           checkCode,
  output logic             needWb,
  output logic [AddrW-1:0] resPa,
  output fault_t           resCode
);
  logic [AddrW-1:0] baseReg;
  logic [AddrW-1:0] vaReg;
  logic [1:0]       kindReg;
  logic [PteW-1:0]  pteReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      vaReg   <= '0;
      kindReg <= '0;
      pteAddr <= '0;
      pteReg  <= '0;
      resPa   <= '0;
      resCode <= fNone;
    end else begin
      if (baseWrEn) baseReg <= baseWrData;
      if (strobe.takeReq) begin
        vaReg   <= reqVa;
        kindReg <= reqKind;
        pteAddr <= baseReg + {reqVa[AddrW-1:OffW], 2'b00};
      end
      if (strobe.takePte) pteReg <= memRdata;
      if (strobe.takeResult) begin
        resCode <= checkCode;
        resPa   <= (checkCode == fNone) ?
                   {pteReg[PfnLo +: VpnW], vaReg[OffW-1:0]} : '0;
      end
    end
  end

  logic       isValid, isRes, permit, isWrite;
  logic [1:0] prot;
  assign isValid = pteReg[ValidB];
  assign isRes   = pteReg[ResB];
  assign prot    = pteReg[ProtLo +: 2];
  assign isWrite = (kindReg == kWrite);

  always_comb begin
    unique case (kindReg)
      kRead:   permit = (prot != 2'b00);
      kWrite:  permit = (prot == 2'b10);
      kFetch:  permit = (prot == 2'b11);
      default: permit = 1'b0;
    endcase
  end

  always_comb begin
    if (!isValid)     checkCode = fInvalid;
    else if (!isRes)  checkCode = fAbsent;
    else if (!permit) checkCode = fProt;
    else              checkCode = fNone;
  end

  assign needWb = !pteReg[RefB] || (isWrite && !pteReg[ModB]);

  always_comb begin
    pteNew       = pteReg;
    pteNew[RefB] = 1'b1;
    if (isWrite) pteNew[ModB] = 1'b1;
  end

  p_pa_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeResult && checkCode == fNone) |=>
      resPa[OffW-1:0] == $past(vaReg[OffW-1:0]))
    else $error("offset not carried");
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReady,
  input  fault_t      checkCode,
  input  logic        needWb,
  output logic        reqReady,
  output logic        memReq,
  output logic        memWe,
  output logic        respValid,
  output pgw_strobe_t strobe
);
  typedef enum logic [2:0] {stIdle, stRead, stCheck, stWb, stDone} st_t;
  st_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= stIdle;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      stIdle:  if (reqValid) nextState = stRead;
      stRead:  if (memReady) nextState = stCheck;
      stCheck: nextState = (checkCode == fNone && needWb) ? stWb : stDone;
      stWb:    if (memReady) nextState = stDone;
      stDone:  nextState = stIdle;
      default: nextState = stIdle;
    endcase
  end

  assign reqReady          = (state == stIdle);
  assign memReq            = (state == stRead) || (state == stWb);
  assign memWe             = (state == stWb);
  assign respValid         = (state == stDone);
  assign strobe.takeReq    = reqReady && reqValid;
  assign strobe.takePte    = (state == stRead) && memReady;
  assign strobe.takeResult = (state == stCheck);

  p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady)
    else $error("ready while busy");

  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid)
    else $error("response longer than one cycle");

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe)))
    else $error("memory request dropped");
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseWrEn,
  input  logic [AddrW-1:0] baseWrData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [AddrW-1:0] reqVa,
  input  logic [1:0]       reqKind,
  output logic             respValid,
  output logic [AddrW-1:0] respPa,
  output logic [1:0]       respCode,
  output logic             memReq,
  output logic             memWe,
  output logic [AddrW-1:0] memAddr,
  output logic [PteW-1:0]  memWdata,
  input  logic             memReady,
  input  logic [PteW-1:0]  memRdata
);
  pgw_strobe_t strobe;
  fault_t      checkCode, resCode;
  logic        needWb;

  pgw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReady(memReady),
    .checkCode(checkCode), .needWb(needWb), .reqReady(reqReady),
    .memReq(memReq), .memWe(memWe), .respValid(respValid), .strobe(strobe)
  );

  pgw_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .reqVa(reqVa), .reqKind(reqKind),
    .memRdata(memRdata), .pteAddr(memAddr), .pteNew(memWdata),
    .checkCode(checkCode), .needWb(needWb), .resPa(respPa), .resCode(resCode)
  );

  assign respCode = resCode;

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> $stable(memAddr))
    else $error("address moved during access");

  p_wb_ref_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> memWdata[RefB])
    else $error("writeback without reference bit");

  p_fault_zero_pa_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode != 2'b00) |-> (respPa == '0))
    else $error("address given on fault");
endmodule

// File: tb/pgw_top_test.sv
module pgw_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic [1:0]  reqKind = '0;
  logic        respValid;
  logic [31:0] respPa;
  logic [1:0]  respCode;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = '0;

  always #4 clk = ~clk;

  pgw_top uut (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa), .reqKind(reqKind),
    .respValid(respValid), .respPa(respPa), .respCode(respCode),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  logic [31:0] pteMem [logic [31:0]];
  logic [31:0] tbBase = '0;
  int readCount = 0, writeCount = 0, respCount = 0, ackTotal = 0;
  int lastAckCyc = 0, waitCnt = 0;
  logic [31:0] lastReadAddr = '0;

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  code;
    int          delay;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model with latency cycling 0..3
  always @(negedge clk) begin
    if (memReady) memReady <= 1'b0;
    else if (rstN && memReq) begin
      if (waitCnt >= (ackTotal % 4)) begin
        memReady   <= 1'b1;
        waitCnt    <= 0;
        ackTotal   <= ackTotal + 1;
        lastAckCyc <= cyc;
        if (memWe) begin
          pteMem[memAddr] = memWdata;
          writeCount <= writeCount + 1;
        end else begin
          memRdata     <= pteMem.exists(memAddr) ? pteMem[memAddr] : 32'h0;
          lastReadAddr <= memAddr;
          readCount    <= readCount + 1;
        end
      end else waitCnt <= waitCnt + 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (expQ.size() == 0) chk(1'b0, "R3", "unexpected response", respPa, 32'h0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        chk(respPa == e.pa, e.tag, "respPa", respPa, e.pa);
        chk(respCode == e.code, e.tag, "respCode", {30'h0, respCode}, {30'h0, e.code});
        chk((cyc - lastAckCyc) == e.delay, "R10", "response delay",
            cyc - lastAckCyc, e.delay);
      end
      respCount <= respCount + 1;
    end
  end

  function automatic logic [31:0] mkPte(bit m, bit r, bit v, logic [1:0] prot,
                                        logic [19:0] pfn, bit res);
    return {m, r, v, prot, pfn, 6'b0, res};
  endfunction

  task automatic setBase(input logic [31:0] b);
    @(negedge clk); baseWrEn = 1'b1; baseWrData = b;
    @(negedge clk); baseWrEn = 1'b0;
    tbBase = b;
  endtask

  task automatic translate(input logic [31:0] va, input logic [1:0] kind,
                           input bit poke, input string tag);
    logic [31:0] pAddr, pte, newPte;
    bit permit, wb;
    logic [1:0] code;
    exp_t e;
    int rd0, wr0, rc0, n;
    pAddr = tbBase + {va[31:12], 2'b00};
    pte = pteMem.exists(pAddr) ? pteMem[pAddr] : 32'h0;
    case (kind)
      2'b00: permit = (pte[28:27] != 2'b00);
      2'b01: permit = (pte[28:27] == 2'b10);
      2'b10: permit = (pte[28:27] == 2'b11);
      default: permit = 1'b0;
    endcase
    if (!pte[29]) code = 2'b01;
    else if (!pte[0]) code = 2'b10;
    else if (!permit) code = 2'b11;
    else code = 2'b00;
    wb = (code == 2'b00) && (!pte[30] || (kind == 2'b01 && !pte[31]));
    newPte = pte;
    if (wb) begin
      newPte[30] = 1'b1;
      if (kind == 2'b01) newPte[31] = 1'b1;
    end
    e.pa = (code == 2'b00) ? {pte[26:7], va[11:0]} : 32'h0;
    e.code = code;
    e.delay = wb ? 1 : 2;
    e.tag = tag;
    expQ.push_back(e);
    rd0 = readCount; wr0 = writeCount; rc0 = respCount;
    @(negedge clk); reqValid = 1'b1; reqVa = va; reqKind = kind;
    @(negedge clk); reqValid = poke; reqVa = ~va; reqKind = 2'b01;
    n = 0;
    while (respCount == rc0 && n < 300) begin @(negedge clk); #1; n++; end
    reqValid = 1'b0;
    chk(respCount == rc0 + 1, tag, "response count", respCount - rc0, 1);
    chk(readCount == rd0 + 1, "R2", "PTE reads", readCount - rd0, 1);
    chk(lastReadAddr == pAddr, "R2", "PTE address", lastReadAddr, pAddr);
    chk(writeCount - wr0 == (wb ? 1 : 0), "R8", "writebacks", writeCount - wr0, wb ? 1 : 0);
    chk((pteMem.exists(pAddr) ? pteMem[pAddr] : 32'h0) == newPte, "R8", "stored PTE",
        pteMem.exists(pAddr) ? pteMem[pAddr] : 32'h0, newPte);
    @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    chk(memReq == 1'b0, "R1", "memReq after reset", memReq, 0);
    chk(respValid == 1'b0, "R1", "respValid after reset", respValid, 0);
    rstN = 1'b1;
    setBase(32'h0001_0000);
    pteMem[32'h0001_0000 + (32'hdeadb << 2)] = mkPte(0, 0, 1, 2'b10, 20'h12345, 1);
    pteMem[32'h0001_0000 + (32'h00001 << 2)] = mkPte(0, 0, 0, 2'b00, 20'h00111, 0);
    pteMem[32'h0001_0000 + (32'h00002 << 2)] = mkPte(0, 0, 1, 2'b00, 20'h00222, 0);
    pteMem[32'h0001_0000 + (32'h00003 << 2)] = mkPte(0, 0, 1, 2'b01, 20'h00333, 1);
    pteMem[32'h0001_0000 + (32'h00004 << 2)] = mkPte(0, 0, 1, 2'b11, 20'h00444, 1);
    pteMem[32'h0001_0000 + (32'h00005 << 2)] = mkPte(0, 0, 1, 2'b00, 20'h00555, 1);
    pteMem[32'h0001_0000 + (32'hfffff << 2)] = mkPte(0, 0, 1, 2'b10, 20'hfffff, 1);
    pteMem[32'h0002_0000 + (32'hdeadb << 2)] = mkPte(1, 1, 1, 2'b10, 20'h0abcd, 1);

    translate(32'hdeadbeef, 2'b00, 0, "R4");
    translate(32'hdeadb123, 2'b01, 1, "R8");
    translate(32'hdeadb456, 2'b01, 0, "R8");
    translate(32'hdeadb789, 2'b00, 1, "R3");
    translate(32'h00001abc, 2'b01, 0, "R5");
    translate(32'h00002abc, 2'b00, 0, "R6");
    translate(32'h00003010, 2'b01, 0, "R7");
    translate(32'h00003020, 2'b00, 0, "R7");
    translate(32'h00003030, 2'b10, 0, "R7");
    translate(32'h00004040, 2'b10, 0, "R7");
    translate(32'h00004050, 2'b01, 0, "R7");
    translate(32'h00005060, 2'b00, 0, "R7");
    translate(32'hdeadb070, 2'b11, 0, "R7");
    translate(32'hffffffff, 2'b01, 0, "R4");
    setBase(32'h0002_0000);
    translate(32'hdeadbeef, 2'b00, 0, "R9");
    chk(expQ.size() == 0, "R10", "pending results", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule